// File: doc/BRIEF.md
# CAN Timeout Down-Counter

This block times out idle periods in a CAN controller. A 16-bit down-counter starts from a programmed period and decrements once per bit-time tick. When it reaches zero it stays there and raises a sticky timeout flag. The flag stays set until software clears it or the counter is reloaded.

Two registers drive the block. The first is a configuration register holding the period, a source select and an enable bit. Writes to it are protected. The second is a counter-value register that shows the live count.

In free-running mode, a write to the counter-value register restarts the count. In the three FIFO-slaved modes, one of three FIFOs drives the counter: the transmit event FIFO, receive FIFO 0 or receive FIFO 1. While the chosen FIFO is empty, the counter is parked at the period. The first element stored into that FIFO starts the count.

The control is a four-state machine:

- **OFF**: disabled, or the cycle just after an accepted configuration write.
- **WAIT**: in a FIFO-slaved mode, waiting for the first store.
- **RUN**: counting down.
- **EXPIRED**: the counter is at zero.

The transitions are:

- Any state goes to OFF on an accepted configuration write or while the enable bit is 0.
- OFF goes to RUN in free-running mode, and to WAIT in a FIFO-slaved mode.
- WAIT goes to RUN on a store to the selected FIFO.
- RUN goes to EXPIRED on a tick while the count is 1 or 0.
- RUN and EXPIRED go to WAIT when the selected FIFO is empty and no store arrives in the same cycle (FIFO-slaved modes).
- RUN and EXPIRED go to RUN, reloaded with the period, on a counter-value write (free-running mode).

Top module: `can_tmo_counter`

## Requirements
- R1: After reset, the configuration register reads 0xFFFF0000, the counter-value register reads 0x0000FFFF and the timeout flag is 0.
- R2: The configuration register holds the period in bits 31:16, the source select in bits 2:1 and the enable bit in bit 0. All other bits read as 0. The counter-value register returns the count in bits 15:0 and 0 above. `reg_sel` = 0 addresses the configuration register and `reg_sel` = 1 the counter-value register.
- R3: A configuration write takes effect only when `cfg_chg_en` and `init_mode` are both 1. Otherwise the register keeps its value.
- R4: While the enable bit is 0, the count is held at the period, ticks and counter-value writes have no effect, and the flag stays 0.
- R5: In RUN the count decreases by exactly one on each clock edge where `bit_tick` is 1, and does not change on other edges. The flag rises on the same edge on which the count reaches 0.
- R6: In free-running mode (select 0), a counter-value write reloads the period, clears the flag, and counting continues on later ticks.
- R7: At zero the count stays 0 under further ticks, and the flag stays 1.
- R8: A pulse on `tmo_clr` clears the flag. If an expiring tick and `tmo_clr` occur in the same cycle, the flag is set.
- R9: Select 1, 2 and 3 slave the counter to `fifo_empty`/`fifo_store` bit 0 (transmit event), bit 1 (receive 0) and bit 2 (receive 1). While that FIFO's empty bit is 1 and no store occurs, the count returns to the period, the flag clears and ticks are ignored.
- R10: In WAIT, a store to the selected FIFO starts counting from the period. Stores and empties of unselected FIFOs have no effect, and a store while counting has no effect.
- R11: In FIFO-slaved modes, counter-value writes have no effect on the count.
- R12: An accepted configuration write clears the flag and loads the new period at once. With the block enabled, counting (free-running) or waiting (FIFO-slaved) begins on the next cycle.
- R13: With a period of 0 in free-running mode, the first tick expires the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_chg_en | input | 1 | Configuration-change enable qualifier |
| init_mode | input | 1 | Controller initialisation qualifier |
| reg_sel | input | 1 | 0: configuration register, 1: counter-value register |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| bit_tick | input | 1 | One-cycle pulse per CAN bit time |
| fifo_empty | input | 3 | Empty level per FIFO: bit 0 transmit event, bit 1 receive 0, bit 2 receive 1 |
| fifo_store | input | 3 | One-cycle store pulse per FIFO, same bit order |
| tmo_clr | input | 1 | Clears the timeout flag |
| tmo_flag | output | 1 | Sticky timeout flag |

## Verification
The countdown is tried under several tick patterns:

- Dense and sparse ticks, with idle gaps between them, separate a counter that counts ticks from one that counts clocks.
- A period of zero probes the edge where the count starts at its end value.
- Ticks after expiry separate a saturating counter from one that wraps.

Each FIFO-slaved mode is also driven with stores and empties on the unselected FIFOs, then on the selected one. This separates a correct source decode from a swapped or ignored one. It also shows that only the first store starts the count, and that an empty FIFO parks the counter.

// File: rtl/tmo_pkg.sv
package tmo_pkg;

    localparam int REG_W    = 32;
    localparam int MODE_W   = 2;
    localparam int NUM_FIFO = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_FREE = 2'd0,
        MODE_TXEV = 2'd1,
        MODE_RX0  = 2'd2,
        MODE_RX1  = 2'd3
    } tmo_mode_e;

    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_WAIT    = 2'd1,
        ST_RUN     = 2'd2,
        ST_EXPIRED = 2'd3
    } tmo_state_e;

endpackage

// File: rtl/tmo_cfg_reg.sv
module tmo_cfg_reg
    import tmo_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_req,
    input  logic [REG_W-1:0]   wdata,
    input  logic               chg_en,
    input  logic               init_on,
    output logic [CNT_W-1:0]   period,
    output logic [CNT_W-1:0]   period_load,
    output tmo_mode_e          mode,
    output logic               en,
    output logic               wr_ok
);
    localparam int PER_LSB = REG_W - CNT_W;

    logic [CNT_W-1:0] new_period;
    logic             unused_wbits;

    assign wr_ok        = wr_req && chg_en && init_on;
    assign new_period   = wdata[REG_W-1:PER_LSB];
    assign period_load  = wr_ok ? new_period : period;
    assign unused_wbits = ^wdata[PER_LSB-1:MODE_W+1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period <= '1;
            mode   <= MODE_FREE;
            en     <= 1'b0;
        end else if (wr_ok) begin
            period <= new_period;
            mode   <= tmo_mode_e'(wdata[MODE_W:1]);
            en     <= wdata[0];
        end
    end

endmodule

// File: rtl/tmo_src_sel.sv
module tmo_src_sel
    import tmo_pkg::*;
(
    input  tmo_mode_e            mode,
    input  logic [NUM_FIFO-1:0]  fifo_empty,
    input  logic [NUM_FIFO-1:0]  fifo_store,
    output logic                 fifo_ctl,
    output logic                 sel_empty,
    output logic                 sel_store
);
    logic [NUM_FIFO-1:0] hit;

    for (genvar g = 0; g < NUM_FIFO; g++) begin : g_hit
        assign hit[g] = (mode == tmo_mode_e'(g + 1));
    end

    assign fifo_ctl  = (mode != MODE_FREE);
    assign sel_empty = |(hit & fifo_empty);
    assign sel_store = |(hit & fifo_store);

endmodule

// File: rtl/tmo_fsm.sv
module tmo_fsm
    import tmo_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               en,
    input  logic [CNT_W-1:0]   period,
    input  logic [CNT_W-1:0]   period_load,
    input  logic               cfg_wr_ok,
    input  logic               fifo_ctl,
    input  logic               sel_empty,
    input  logic               sel_store,
    input  logic               cnt_wr,
    input  logic               clr,
    output logic [CNT_W-1:0]   cnt,
    output logic               flag
);
    tmo_state_e state_q, state_d;
    logic       reload;
    logic       last_step;

    // restart condition while running or expired
    assign reload    = fifo_ctl ? (sel_empty && !sel_store) : cnt_wr;
    assign last_step = tick && (cnt <= CNT_W'(1));

    always_comb begin
        state_d = state_q;
        if (cfg_wr_ok || !en) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:     state_d = fifo_ctl ? ST_WAIT : ST_RUN;
                ST_WAIT:    if (sel_store) state_d = ST_RUN;
                ST_RUN: begin
                    if (reload)         state_d = fifo_ctl ? ST_WAIT : ST_RUN;
                    else if (last_step) state_d = ST_EXPIRED;
                end
                ST_EXPIRED: if (reload) state_d = fifo_ctl ? ST_WAIT : ST_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '1;
            flag <= 1'b0;
        end else if (cfg_wr_ok || !en) begin
            cnt  <= period_load;
            flag <= 1'b0;
        end else begin
            unique case (state_q)
                ST_OFF, ST_WAIT: begin
                    cnt  <= period;
                    flag <= 1'b0;
                end
                ST_RUN: begin
                    if (reload) begin
                        cnt  <= period;
                        flag <= 1'b0;
                    end else if (last_step) begin
                        cnt  <= '0;
                        flag <= 1'b1;
                    end else begin
                        if (tick) cnt <= cnt - CNT_W'(1);
                        flag <= flag && !clr;
                    end
                end
                ST_EXPIRED: begin
                    if (reload) begin
                        cnt  <= period;
                        flag <= 1'b0;
                    end else begin
                        cnt  <= '0;
                        flag <= flag && !clr;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/can_tmo_counter.sv
module can_tmo_counter
    import tmo_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_chg_en,
    input  logic                 init_mode,
    input  logic                 reg_sel,
    input  logic                 reg_wr,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    input  logic                 bit_tick,
    input  logic [NUM_FIFO-1:0]  fifo_empty,
    input  logic [NUM_FIFO-1:0]  fifo_store,
    input  logic                 tmo_clr,
    output logic                 tmo_flag
);
    localparam int PER_LSB = REG_W - CNT_W;

    logic [CNT_W-1:0] cfg_period;
    logic [CNT_W-1:0] period_load;
    tmo_mode_e        cfg_mode;
    logic             cfg_en;
    logic             cfg_wr_ok;
    logic             fifo_ctl, sel_empty, sel_store;
    logic [CNT_W-1:0] cnt_q;

    tmo_cfg_reg #(.CNT_W(CNT_W)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_req      (reg_wr && !reg_sel),
        .wdata       (reg_wdata),
        .chg_en      (cfg_chg_en),
        .init_on     (init_mode),
        .period      (cfg_period),
        .period_load (period_load),
        .mode        (cfg_mode),
        .en          (cfg_en),
        .wr_ok       (cfg_wr_ok)
    );

    tmo_src_sel u_sel (
        .mode       (cfg_mode),
        .fifo_empty (fifo_empty),
        .fifo_store (fifo_store),
        .fifo_ctl   (fifo_ctl),
        .sel_empty  (sel_empty),
        .sel_store  (sel_store)
    );

    tmo_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (bit_tick),
        .en          (cfg_en),
        .period      (cfg_period),
        .period_load (period_load),
        .cfg_wr_ok   (cfg_wr_ok),
        .fifo_ctl    (fifo_ctl),
        .sel_empty   (sel_empty),
        .sel_store   (sel_store),
        .cnt_wr      (reg_wr && reg_sel),
        .clr         (tmo_clr),
        .cnt         (cnt_q),
        .flag        (tmo_flag)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_sel) begin
            reg_rdata[CNT_W-1:0] = cnt_q;
        end else begin
            reg_rdata[REG_W-1:PER_LSB] = cfg_period;
            reg_rdata[MODE_W:1]        = cfg_mode;
            reg_rdata[0]               = cfg_en;
        end
    end

endmodule

// File: rtl/tmo_counter_chk.sv
module tmo_counter_chk
    import tmo_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_sel,
    input logic                 reg_wr,
    input logic                 cfg_chg_en,
    input logic                 init_mode,
    input logic [NUM_FIFO-1:0]  fifo_empty,
    input logic [NUM_FIFO-1:0]  fifo_store,
    input logic                 tmo_flag,
    input logic [CNT_W-1:0]     cfg_period,
    input tmo_mode_e            cfg_mode,
    input logic                 cfg_en,
    input logic                 cfg_wr_ok,
    input logic [CNT_W-1:0]     cnt_q
);
    assert_locked_cfg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_sel && !(cfg_chg_en && init_mode))
        |=> $stable({cfg_period, cfg_mode, cfg_en}));

    assert_disabled_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en && !cfg_wr_ok) |=> (cnt_q == $past(cfg_period) && !tmo_flag));

    assert_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q < $past(cnt_q)) |-> (cnt_q == $past(cnt_q) - CNT_W'(1) || cnt_q == cfg_period));

    assert_flag_at_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_flag) |-> (cnt_q == '0));

    assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q > $past(cnt_q)) |-> (cnt_q == cfg_period));

    assert_fifo_park_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && cfg_mode != MODE_FREE && !cfg_wr_ok
         && fifo_empty[cfg_mode - 2'd1] && !fifo_store[cfg_mode - 2'd1])
        |=> (cnt_q == $past(cfg_period) && !tmo_flag));

endmodule

bind can_tmo_counter tmo_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_sel    (reg_sel),
    .reg_wr     (reg_wr),
    .cfg_chg_en (cfg_chg_en),
    .init_mode  (init_mode),
    .fifo_empty (fifo_empty),
    .fifo_store (fifo_store),
    .tmo_flag   (tmo_flag),
    .cfg_period (cfg_period),
    .cfg_mode   (cfg_mode),
    .cfg_en     (cfg_en),
    .cfg_wr_ok  (cfg_wr_ok),
    .cnt_q      (cnt_q)
);

// File: tb/can_tmo_counter_tb.sv
module can_tmo_counter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_chg_en = 1'b1;
    logic        init_mode = 1'b1;
    logic        reg_sel = 1'b1;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        bit_tick = 1'b0;
    logic [2:0]  fifo_empty = 3'b111;
    logic [2:0]  fifo_store = 3'b000;
    logic        tmo_clr = 1'b0;
    logic        tmo_flag;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_tmo_counter u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_chg_en(cfg_chg_en), .init_mode(init_mode),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bit_tick(bit_tick), .fifo_empty(fifo_empty), .fifo_store(fifo_store),
        .tmo_clr(tmo_clr), .tmo_flag(tmo_flag)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WDOG_LIMIT) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WDOG_LIMIT);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg_wr(input logic [31:0] d);
        reg_sel = 1'b0; reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_sel = 1'b1;
    endtask

    task automatic cnt_wr();
        reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = 32'h0000_0042;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic tick(input int n);
        repeat (n) begin
            bit_tick = 1'b1;
            @(negedge clk);
            bit_tick = 1'b0;
        end
    endtask

    task automatic rd(input logic sel, output logic [31:0] v);
        reg_sel = sel;
        #1 v = reg_rdata;
        reg_sel = 1'b1;
    endtask

    task automatic check_cnt(input string tag, input logic [31:0] exp_cnt, input logic exp_flag);
        logic [31:0] v;
        rd(1'b1, v);
        check({tag, " count"}, v, exp_cnt);
        check({tag, " flag"}, {31'd0, tmo_flag}, {31'd0, exp_flag});
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(1'b0, v);
        check("R1 cfg reset", v, 32'hFFFF_0000);
        check_cnt("R1", 32'h0000_FFFF, 1'b0);
    endtask

    task automatic t_lock();
        logic [31:0] v;
        cfg_chg_en = 1'b1; init_mode = 1'b0;
        cfg_wr(32'h0010_0003);
        rd(1'b0, v);
        check("R3 init low", v, 32'hFFFF_0000);
        cfg_chg_en = 1'b0; init_mode = 1'b1;
        cfg_wr(32'h0010_0003);
        rd(1'b0, v);
        check("R3 cce low", v, 32'hFFFF_0000);
        cfg_chg_en = 1'b1; init_mode = 1'b1;
    endtask

    task automatic t_layout();
        logic [31:0] v;
        cfg_wr(32'h1234_FFFF);
        rd(1'b0, v);
        check("R2 field layout", v, 32'h1234_0007);
        rd(1'b1, v);
        check("R2 count readback", v, 32'h0000_1234);
    endtask

    task automatic t_disabled();
        cfg_wr(32'h0005_0000);
        idle(1);
        tick(3);
        cnt_wr();
        check_cnt("R4 disabled", 32'd5, 1'b0);
    endtask

    task automatic t_free_run();
        cfg_wr(32'h0005_0001);
        idle(1);
        tick(4);
        check_cnt("R5 after 4 ticks", 32'd1, 1'b0);
        idle(3);
        check_cnt("R5 no tick gap", 32'd1, 1'b0);
        tick(1);
        check_cnt("R5 expiry", 32'd0, 1'b1);
        tick(3);
        check_cnt("R7 saturate", 32'd0, 1'b1);
        cnt_wr();
        check_cnt("R6 reload", 32'd5, 1'b0);
        tick(2);
        check_cnt("R6 continues", 32'd3, 1'b0);
    endtask

    task automatic t_clear();
        tick(3);
        check_cnt("R8 expired", 32'd0, 1'b1);
        tmo_clr = 1'b1;
        @(negedge clk);
        tmo_clr = 1'b0;
        check_cnt("R8 clr", 32'd0, 1'b0);
        cnt_wr();
        tick(4);
        bit_tick = 1'b1; tmo_clr = 1'b1;
        @(negedge clk);
        bit_tick = 1'b0; tmo_clr = 1'b0;
        check_cnt("R8 expiry beats clr", 32'd0, 1'b1);
    endtask

    task automatic t_zero_period();
        cfg_wr(32'h0000_0001);
        idle(1);
        check_cnt("R13 before tick", 32'd0, 1'b0);
        tick(1);
        check_cnt("R13 first tick", 32'd0, 1'b1);
        cfg_wr(32'h0009_0001);
        check_cnt("R12 new period", 32'd9, 1'b0);
        idle(1);
        tick(1);
        check_cnt("R12 counting", 32'd8, 1'b0);
    endtask

    task automatic t_fifo_rx0();
        cfg_wr(32'h0006_0005);
        idle(1);
        tick(3);
        check_cnt("R9 parked", 32'd6, 1'b0);
        fifo_store = 3'b101;
        @(negedge clk);
        fifo_store = 3'b000;
        tick(2);
        check_cnt("R10 other fifo store", 32'd6, 1'b0);
        fifo_store = 3'b010; fifo_empty = 3'b101;
        @(negedge clk);
        fifo_store = 3'b000;
        tick(2);
        check_cnt("R10 started", 32'd4, 1'b0);
        fifo_store = 3'b010;
        @(negedge clk);
        fifo_store = 3'b000;
        tick(1);
        check_cnt("R10 second store", 32'd3, 1'b0);
        cnt_wr();
        fifo_empty = 3'b100;
        idle(1);
        fifo_empty = 3'b101;
        check_cnt("R11 value write ignored", 32'd3, 1'b0);
        tick(3);
        check_cnt("R10 expiry", 32'd0, 1'b1);
        fifo_empty = 3'b111;
        @(negedge clk);
        check_cnt("R9 empty reload", 32'd6, 1'b0);
        tick(2);
        check_cnt("R9 ticks ignored", 32'd6, 1'b0);
    endtask

    task automatic t_fifo_others();
        cfg_wr(32'h0004_0007);
        idle(1);
        fifo_store = 3'b100; fifo_empty = 3'b011;
        @(negedge clk);
        fifo_store = 3'b000;
        tick(1);
        check_cnt("R10 rx1 select", 32'd3, 1'b0);
        fifo_empty = 3'b111;
        cfg_wr(32'h0003_0003);
        idle(1);
        fifo_store = 3'b001; fifo_empty = 3'b110;
        @(negedge clk);
        fifo_store = 3'b000;
        tick(3);
        check_cnt("R10 txev select", 32'd0, 1'b1);
        fifo_empty = 3'b111;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_lock();
        t_layout();
        t_disabled();
        t_free_run();
        t_clear();
        t_zero_period();
        t_fifo_rx0();
        t_fifo_others();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule